// File: doc/BRIEF.md
# I2C High-Speed Slave Controller

This block is an I2C slave for a bus that may switch into the high-speed transfer mode. The SCL and SDA pins are oversampled by the system clock through a synchronizer. START, repeated START and STOP are detected on the synchronized samples. When high-speed operation is enabled, a byte of the form 0000_1xxx received first after a START counts as a master code. The slave leaves SDA released for its acknowledge slot. It enters high-speed mode on the next repeated START and stays there until a STOP.

After an address byte that matches the configured 7-bit address, the slave takes write data into one receive holding register or sends bytes from one transmit holding register. It never holds SCL low. If software reads a byte too late, the block reports an overrun. If software supplies a byte too late, it reports an underrun. SDA is driven as an open-drain enable: when `sda_oe_o` is high, the pad pulls the line low.

Top module: `i2c_hs_slave`

## Requirements
- R1: After reset the slave drives nothing (`sda_oe_o`=0), `hs_mode_o`=0, `rxrdy_o`=0, `txrdy_o`=1, `ovr_o`=0 and `udr_o`=0.
- R2: The first byte after a START or repeated START is received MSB first, sampled on SCL rising edges. Bits [7:1] hold the address and bit 0 holds R/W, with 1 meaning read. The slave pulls SDA low in the ninth clock only when bits [7:1] equal `cfg_addr_i`. Otherwise it keeps SDA released until the next START or STOP.
- R3: With `cfg_hs_en_i`=1 and the slave not in high-speed mode, a first byte whose bits [7:3] are 00001 is not acknowledged. `hs_mode_o` stays 0 until the next repeated START and is 1 after it.
- R4: With `cfg_hs_en_i`=0, a 0000_1xxx byte is handled as an ordinary address byte, and a following repeated START leaves `hs_mode_o` at 0.
- R5: Further repeated STARTs keep `hs_mode_o` at 1. A STOP clears it, and a later frame without a master code stays in normal mode.
- R6: In a write transfer, each data byte is acknowledged, appears on `rx_data_o`, and sets `rxrdy_o`. A one-cycle `rx_rd_i` pulse clears `rxrdy_o`.
- R7: A write byte that completes while `rxrdy_o` is 1 sets `ovr_o`. That byte is still acknowledged but is dropped, and `rx_data_o` keeps the unread byte.
- R8: In a read transfer, the transmit holding byte is sent MSB first, with a 0 bit driven low and a 1 bit released. Loading a byte into the shifter sets `txrdy_o`, and a `tx_wr_i` pulse stores `tx_data_i` and clears `txrdy_o`. A master ACK starts the next byte. A master NACK makes the slave release SDA until START or STOP.
- R9: A byte that must be sent while `txrdy_o` is 1 sets `udr_o`, and 0xFF is sent instead.
- R10: `ovr_o` and `udr_o` stay set across STOP and new frames until a `stat_rd_i` pulse clears them.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_i | input | 7 | Own slave address |
| cfg_hs_en_i | input | 1 | Enables master code matching |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| hs_mode_o | output | 1 | High-speed period active |
| rx_data_o | output | 8 | Receive holding register |
| rx_rd_i | input | 1 | Read strobe for the receive register |
| tx_data_i | input | 8 | Byte to transmit |
| tx_wr_i | input | 1 | Write strobe for the transmit register |
| stat_rd_i | input | 1 | Status read, clears the sticky flags |
| rxrdy_o | output | 1 | Receive register holds an unread byte |
| txrdy_o | output | 1 | Transmit register is empty |
| ovr_o | output | 1 | Sticky receive overrun |
| udr_o | output | 1 | Sticky transmit underrun |

## Verification
An edge on a bus pin reaches the byte engine after the two synchronizer flops and the edge register. Every SDA drive change, acknowledge, flag update or mode change is therefore registered by the third clock after the pin edge. The master model holds each SCL phase for at least five clocks. It samples acknowledges and read bits half a phase after SCL rises, and checks flags after the ninth SCL falling edge plus a few idle cycles. Every result is settled well before it is observed. Host-side strobes act on the next clock edge, and the bench reads the flags one cycle later.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RXB,
    ST_ACK,
    ST_TXB,
    ST_TXACK,
    ST_WAIT
  } hs_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;
  // upper five bits of a high-speed master code
  localparam logic [4:0] MCODE_HI = 5'b00001;
endpackage

// File: rtl/i2c_hs_sync.sv
module i2c_hs_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_hs_cond.sv
module i2c_hs_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edges count as conditions only with SCL high on both samples
  assign start_o = scl_i & scl_q &  sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q &  sda_i;
  assign rise_o  =  scl_i & ~scl_q;
  assign fall_o  = ~scl_i &  scl_q;
endmodule

// File: rtl/i2c_hs_slave.sv
module i2c_hs_slave
  import i2c_hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              cfg_hs_en_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              hs_mode_o,
  output logic [BYTE_W-1:0] rx_data_o,
  input  logic              rx_rd_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_wr_i,
  input  logic              stat_rd_i,
  output logic              rxrdy_o,
  output logic              txrdy_o,
  output logic              ovr_o,
  output logic              udr_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic [1:0] pins, pins_s;
  logic       scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;

  assign pins = {scl_i, sda_i};

  i2c_hs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins),
    .q_o   (pins_s)
  );

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  i2c_hs_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_s),
    .sda_i  (sda_s),
    .start_o(start_det),
    .stop_o (stop_det),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  hs_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rsh_q, tsh_q, rx_hold_q, tx_hold_q;
  logic              addr_ph_q, rw_q, mack_q, mc_seen_q, hs_q, oe_q;
  logic              rxrdy_q, txrdy_q, ovr_q, udr_q;

  // effective transmit register view, a same-cycle write counts
  logic              ld_empty;
  logic [BYTE_W-1:0] ld_byte;
  assign ld_empty = txrdy_q & ~tx_wr_i;
  assign ld_byte  = tx_wr_i ? tx_data_i : tx_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      rsh_q     <= '0;
      tsh_q     <= '1;
      rx_hold_q <= '0;
      tx_hold_q <= '0;
      addr_ph_q <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      mc_seen_q <= 1'b0;
      hs_q      <= 1'b0;
      oe_q      <= 1'b0;
      rxrdy_q   <= 1'b0;
      txrdy_q   <= 1'b1;
      ovr_q     <= 1'b0;
      udr_q     <= 1'b0;
    end else begin
      if (rx_rd_i) rxrdy_q <= 1'b0;
      if (tx_wr_i) begin
        tx_hold_q <= tx_data_i;
        txrdy_q   <= 1'b0;
      end
      if (stat_rd_i) begin
        ovr_q <= 1'b0;
        udr_q <= 1'b0;
      end

      if (stop_det) begin
        state_q   <= ST_IDLE;
        oe_q      <= 1'b0;
        hs_q      <= 1'b0;
        mc_seen_q <= 1'b0;
      end else if (start_det) begin
        if (mc_seen_q) hs_q <= 1'b1;
        state_q   <= ST_RXB;
        addr_ph_q <= 1'b1;
        cnt_q     <= '0;
        oe_q      <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RXB: begin
            if (scl_rise && cnt_q != CNT_W'(BYTE_W)) begin
              rsh_q <= {rsh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
              if (addr_ph_q) begin
                addr_ph_q <= 1'b0;
                if (cfg_hs_en_i && !hs_q && rsh_q[7:3] == MCODE_HI) begin
                  mc_seen_q <= 1'b1;
                  state_q   <= ST_WAIT;
                end else if (rsh_q[7:1] == cfg_addr_i) begin
                  rw_q    <= rsh_q[0];
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else begin
                if (rxrdy_q && !rx_rd_i) begin
                  ovr_q <= 1'b1;
                end else begin
                  rx_hold_q <= rsh_q;
                  rxrdy_q   <= 1'b1;
                end
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                if (ld_empty) begin
                  udr_q <= 1'b1;
                  tsh_q <= '1;
                  oe_q  <= 1'b0;
                end else begin
                  tsh_q   <= ld_byte;
                  oe_q    <= ~ld_byte[BYTE_W-1];
                  txrdy_q <= 1'b1;
                end
                state_q <= ST_TXB;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_RXB;
              end
            end
          end
          ST_TXB: begin
            if (scl_fall) begin
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                oe_q    <= 1'b0;
                state_q <= ST_TXACK;
              end else begin
                tsh_q <= {tsh_q[BYTE_W-2:0], 1'b1};
                oe_q  <= ~tsh_q[BYTE_W-2];
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                cnt_q <= '0;
                if (ld_empty) begin
                  udr_q <= 1'b1;
                  tsh_q <= '1;
                  oe_q  <= 1'b0;
                end else begin
                  tsh_q   <= ld_byte;
                  oe_q    <= ~ld_byte[BYTE_W-1];
                  txrdy_q <= 1'b1;
                end
                state_q <= ST_TXB;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign hs_mode_o = hs_q;
  assign rx_data_o = rx_hold_q;
  assign rxrdy_o   = rxrdy_q;
  assign txrdy_o   = txrdy_q;
  assign ovr_o     = ovr_q;
  assign udr_o     = udr_q;
endmodule

// File: rtl/i2c_hs_slave_chk.sv
module i2c_hs_slave_chk
  import i2c_hs_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      scl_s,
  input logic      start_det,
  input logic      stop_det,
  input logic      sda_oe_o,
  input logic      hs_mode_o,
  input logic      rxrdy_o,
  input logic      txrdy_o,
  input logic      ovr_o,
  input logic      udr_o,
  input hs_state_e st
);
  // R11
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  // R2
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE || st == ST_WAIT) |-> !sda_oe_o);

  // R3
  hs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_mode_o) |-> $past(start_det));

  // R5
  hs_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_det) |-> !hs_mode_o);

  // R7
  ovr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(rxrdy_o));

  // R9
  udr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(udr_o) |-> $past(txrdy_o));
endmodule

bind i2c_hs_slave i2c_hs_slave_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_s),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe_o (sda_oe_o),
  .hs_mode_o(hs_mode_o),
  .rxrdy_o  (rxrdy_o),
  .txrdy_o  (txrdy_o),
  .ovr_o    (ovr_o),
  .udr_o    (udr_o),
  .st       (state_q)
);

// File: tb/sim_i2c_hs_slave.sv
`timescale 1ns/1ps
module sim_i2c_hs_slave;
  localparam logic [6:0] OWN = 7'h52;
  localparam int FS_HP = 10;
  localparam int HS_HP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic       hs_en = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe, hs_mode, rxrdy, txrdy, ovr, udr;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;
  logic       rx_rd = 1'b0, tx_wr = 1'b0, stat_rd = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  i2c_hs_slave u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_addr_i (OWN),
    .cfg_hs_en_i(hs_en),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .hs_mode_o  (hs_mode),
    .rx_data_o  (rx_data),
    .rx_rd_i    (rx_rd),
    .tx_data_i  (tx_data),
    .tx_wr_i    (tx_wr),
    .stat_rd_i  (stat_rd),
    .rxrdy_o    (rxrdy),
    .txrdy_o    (txrdy),
    .ovr_o      (ovr),
    .udr_o      (udr)
  );

  int n_run = 0, n_fail = 0;
  int hp = FS_HP;
  int oe_viol = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R11 monitor: drive changes seen while the SCL pin is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic bus_start();
    sda_m = 1'b1; wt(hp);
    scl_m = 1'b1; wt(hp);
    sda_m = 1'b0; wt(hp);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(hp);
    scl_m = 1'b1; wt(hp);
    sda_m = 1'b1; wt(hp);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(hp);
      scl_m = 1'b1; wt(hp);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(hp);
    scl_m = 1'b1; wt(hp / 2);
    ack = ~sda_line;
    wt(hp - hp / 2);
    scl_m = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(hp);
      scl_m = 1'b1; wt(hp / 2);
      b[i] = sda_line;
      wt(hp - hp / 2);
      scl_m = 1'b0;
    end
    sda_m = ~mack; wt(hp);
    scl_m = 1'b1; wt(hp);
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic pulse_rd();   rx_rd = 1'b1; wt(1); rx_rd = 1'b0; wt(1); endtask
  task automatic pulse_stat(); stat_rd = 1'b1; wt(1); stat_rd = 1'b0; wt(1); endtask
  task automatic put_tx(input logic [7:0] b);
    tx_data = b; tx_wr = 1'b1; wt(1); tx_wr = 1'b0; wt(1);
  endtask

  // master code then repeated START into high-speed timing
  task automatic enter_hs(input logic [7:0] mc);
    logic a;
    hp = FS_HP;
    bus_start();
    write_byte(mc, a);
    check("R3 master code nack", a, 0);
    check("R3 no hs before Sr", hs_mode, 0);
    hp = HS_HP;
    bus_start();
    wt(2);
    check("R3 hs after Sr", hs_mode, 1);
  endtask

  task automatic t_reset();
    check("R1 sda_oe", sda_oe, 0);
    check("R1 hs_mode", hs_mode, 0);
    check("R1 rxrdy", rxrdy, 0);
    check("R1 txrdy", txrdy, 1);
    check("R1 ovr", ovr, 0);
    check("R1 udr", udr, 0);
  endtask

  task automatic t_hs_write();
    logic a;
    enter_hs(8'h09);
    write_byte({OWN, 1'b0}, a);
    check("R2 address ack", a, 1);
    write_byte(8'hA5, a);
    check("R6 data ack", a, 1);
    wt(3);
    check("R6 rxrdy set", rxrdy, 1);
    check("R6 rx data", rx_data, 8'hA5);
    pulse_rd();
    check("R6 rxrdy clear", rxrdy, 0);
    write_byte(8'h3C, a);
    wt(3);
    check("R6 second byte", rx_data, 8'h3C);
    pulse_rd();
    bus_stop();
    wt(2);
    check("R5 stop clears hs", hs_mode, 0);
    check("R7 no overrun", ovr, 0);
  endtask

  task automatic t_hs_read();
    logic a;
    logic [7:0] b;
    put_tx(8'hC3);
    check("R8 txrdy clear on write", txrdy, 0);
    enter_hs(8'h0E);
    write_byte({OWN, 1'b1}, a);
    check("R2 read address ack", a, 1);
    wt(4);
    check("R8 txrdy after load", txrdy, 1);
    put_tx(8'h5A);
    read_byte(b, 1'b1);
    check("R8 first byte", b, 8'hC3);
    read_byte(b, 1'b0);
    check("R8 second byte", b, 8'h5A);
    wt(3);
    check("R8 released after nack", sda_oe, 0);
    check("R9 no underrun", udr, 0);
    bus_stop();
  endtask

  task automatic t_rstart_hs();
    logic a;
    enter_hs(8'h0B);
    write_byte({7'h31, 1'b0}, a);
    check("R2 mismatch nack", a, 0);
    bus_start();
    wt(2);
    check("R5 hs kept over Sr", hs_mode, 1);
    write_byte({OWN, 1'b0}, a);
    check("R2 ack after Sr", a, 1);
    write_byte(8'h77, a);
    wt(3);
    check("R6 data after Sr", rx_data, 8'h77);
    pulse_rd();
    bus_stop();
    hp = FS_HP;
    bus_start();
    write_byte({OWN, 1'b0}, a);
    check("R5 fs address ack", a, 1);
    check("R5 stays fs", hs_mode, 0);
    bus_stop();
  endtask

  task automatic t_hs_disabled();
    logic a;
    hs_en = 1'b0;
    hp = FS_HP;
    bus_start();
    write_byte(8'h09, a);
    check("R4 treated as address, nack", a, 0);
    bus_start();
    wt(2);
    check("R4 no hs entry", hs_mode, 0);
    bus_stop();
    hs_en = 1'b1;
  endtask

  task automatic t_overrun();
    logic a;
    enter_hs(8'h08);
    write_byte({OWN, 1'b0}, a);
    write_byte(8'h11, a);
    write_byte(8'h22, a);
    check("R7 overrun byte acked", a, 1);
    wt(3);
    check("R7 ovr set", ovr, 1);
    check("R7 held byte kept", rx_data, 8'h11);
    bus_stop();
    check("R10 ovr sticky", ovr, 1);
    pulse_stat();
    check("R10 ovr cleared", ovr, 0);
    pulse_rd();
  endtask

  task automatic t_underrun();
    logic a;
    logic [7:0] b;
    check("R9 tx empty", txrdy, 1);
    enter_hs(8'h0F);
    write_byte({OWN, 1'b1}, a);
    wt(4);
    check("R9 udr set", udr, 1);
    read_byte(b, 1'b0);
    check("R9 sends ff", b, 8'hFF);
    bus_stop();
    check("R10 udr sticky", udr, 1);
    pulse_stat();
    check("R10 udr cleared", udr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wt(3);
    rst_n = 1'b1;
    wt(3);
    t_reset();
    t_hs_write();
    t_hs_read();
    t_rstart_hs();
    t_hs_disabled();
    t_overrun();
    t_underrun();
    check("R11 drive changes with SCL high", oe_viol, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule